// File: doc/BRIEF.md
# USB Event Interrupt Router

This block gathers the event pulses of a USB full-speed device core into a sticky pending register. It pairs that register with a per-event enable mask and drives three level interrupt lines. The general line carries every enabled event, so its handler has to read the pending register to learn the cause. The fast line is reserved for completed transfers on endpoints that need low latency: isochronous endpoints and bulk endpoints that use two alternating buffers. The wake line reports a resume request that arrives while the device is suspended.

Software reads the block through a small register port with one cycle of read latency. Writing a 0 to a bit of the pending register acknowledges that event. The block also keeps the endpoint number and the direction of the last completed transfer, which lets the handler find the endpoint that finished. Endpoint 0 always serves control traffic with a single buffer, so its completions never reach the fast line.

Top module: `usb_irq_router`

## Requirements
- R1: After synchronous reset the pending register, the mask register, the transfer-info register, `rd_data` and all three interrupt outputs are zero.
- R2: A one-cycle event pulse sets its pending bit at the next clock edge, and the bit stays set until software clears it. Pending bit layout: bit 0 is any completed transfer, bit 1 is a fast-class completed transfer, bit 2 is bus reset, bit 3 is suspend, bit 4 is wakeup, and bits 5 and up are the generic events (`ev_gen[k]` sets bit 5+k).
- R3: A write to address 0 (pending) clears every bit whose written value is 0 and leaves every bit whose written value is 1 unchanged.
- R4: If an event pulse and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R5: `irq_lo` is a registered level equal to the OR of (pending AND mask) over every bit except bit 1. It follows the pending and mask state one cycle later.
- R6: `irq_hi` is a registered level equal to pending bit 1 AND mask bit 1. Bit 1 sets only on a completed transfer that has `ev_xfer_fast` high and a nonzero endpoint number.
- R7: A completed transfer on endpoint 0 sets bit 0 but never sets bit 1, even when `ev_xfer_fast` is high.
- R8: A wakeup pulse sets bit 4 only while `susp_mode` is high, and has no effect otherwise. `irq_wake` is the registered value of pending bit 4 AND mask bit 4.
- R9: The mask register at address 1 can be read and written. A masked event is still recorded in the pending register but drives no line.
- R10: Address 2 holds the last completed transfer: the endpoint number in bits [EP_W-1:0] and the direction (1 = IN) in bit EP_W. The register updates on every completed transfer and ignores writes.
- R11: `rd_data` shows the register selected by `rd_addr` one clock after the address is presented. Addresses 0 to 2 are as above, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_xfer | input | 1 | Completed-transfer pulse |
| ev_xfer_ep | input | EP_W | Endpoint number of the completed transfer |
| ev_xfer_in | input | 1 | Direction of the completed transfer, 1 = IN |
| ev_xfer_fast | input | 1 | Endpoint is isochronous or double-buffered bulk |
| ev_bus_reset | input | 1 | Bus reset pulse |
| ev_suspend | input | 1 | Suspend pulse |
| ev_wakeup | input | 1 | Wakeup pulse |
| ev_gen | input | NUM_GEN | Generic event pulses |
| susp_mode | input | 1 | Peripheral is in suspend mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW | Registered read data |
| irq_lo | output | 1 | General interrupt line |
| irq_hi | output | 1 | Fast transfer interrupt line |
| irq_wake | output | 1 | Wake-from-suspend interrupt line |

## Verification
The bench drives an event pulse and a clearing write into the same bit in the same cycle. A design that let the clear win would lose that event. It sends fast-flagged transfers on endpoint 0 and on a nonzero endpoint, so a design that skipped the endpoint-0 exclusion would raise `irq_hi` for control traffic. Wakeup pulses arrive both inside and outside suspend, and an early wake line would show up as a stray bit 4 or a raised `irq_wake`. The bench also writes 1s to the pending register and writes to the read-only info register. A design that treated those writes as plain stores would change state that must hold.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int B_XFER    = 0;
  localparam int B_FAST    = 1;
  localparam int B_BRST    = 2;
  localparam int B_SUSP    = 3;
  localparam int B_WAKE    = 4;
  localparam int NUM_FIXED = 5;

  typedef enum logic [1:0] {
    RA_PEND  = 2'd0,
    RA_MASK  = 2'd1,
    RA_XINFO = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_irq_pending.sv
module usb_irq_pending
  import usb_irq_pkg::*;
#(
  parameter int EP_W    = 4,
  parameter int NUM_GEN = 4,
  localparam int NEV    = NUM_FIXED + NUM_GEN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_xfer,
  input  logic [EP_W-1:0]    ev_xfer_ep,
  input  logic               ev_xfer_fast,
  input  logic               ev_bus_reset,
  input  logic               ev_suspend,
  input  logic               ev_wakeup,
  input  logic [NUM_GEN-1:0] ev_gen,
  input  logic               susp_mode,
  input  logic [NEV-1:0]     clr_vec,
  output logic [NEV-1:0]     pend
);
  logic [NEV-1:0] set_vec;
  logic           ep_nonzero;

  assign ep_nonzero = |ev_xfer_ep;

  always_comb begin
    set_vec         = '0;
    set_vec[B_XFER] = ev_xfer;
    set_vec[B_FAST] = ev_xfer && ev_xfer_fast && ep_nonzero;
    set_vec[B_BRST] = ev_bus_reset;
    set_vec[B_SUSP] = ev_suspend;
    set_vec[B_WAKE] = ev_wakeup && susp_mode;
    set_vec[NEV-1:NUM_FIXED] = ev_gen;
  end

  for (genvar i = 0; i < NEV; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             pend[i] <= 1'b0;
      else if (set_vec[i]) pend[i] <= 1'b1;
      else if (clr_vec[i]) pend[i] <= 1'b0;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> pend[i]);  // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!set_vec[i] && !clr_vec[i]) |=> $stable(pend[i]));  // R2
  end

  AST_EP0_NOT_FAST: assert property (@(posedge clk) disable iff (rst)
    (ev_xfer && ev_xfer_ep == '0 && !pend[B_FAST]) |=> !pend[B_FAST]);  // R7
  AST_WAKE_NEEDS_SUSP: assert property (@(posedge clk) disable iff (rst)
    (!susp_mode && !pend[B_WAKE]) |=> !pend[B_WAKE]);  // R8
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
#(
  parameter int EP_W    = 4,
  parameter int NUM_GEN = 4,
  parameter int DW      = 16,
  localparam int NEV    = NUM_FIXED + NUM_GEN,
  localparam int XW     = EP_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_xfer,
  input  logic [EP_W-1:0] ev_xfer_ep,
  input  logic            ev_xfer_in,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  input  logic [NEV-1:0]  pend,
  output logic [NEV-1:0]  mask,
  output logic [NEV-1:0]  clr_vec,
  output logic [DW-1:0]   rd_data
);
  logic [XW-1:0] xinfo;
  logic          wr_pend, wr_mask;

  assign wr_pend = wr_en && (wr_addr == RA_PEND);
  assign wr_mask = wr_en && (wr_addr == RA_MASK);
  assign clr_vec = wr_pend ? ~wr_data[NEV-1:0] : '0;

  if (DW > NEV) begin : g_spare
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DW-1:NEV];
  end

  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (wr_mask) mask <= wr_data[NEV-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          xinfo <= '0;
    else if (ev_xfer) xinfo <= {ev_xfer_in, ev_xfer_ep};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_addr)
        RA_PEND:  rd_data <= DW'(pend);
        RA_MASK:  rd_data <= DW'(mask);
        RA_XINFO: rd_data <= DW'(xinfo);
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask));  // R9
  AST_XINFO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ev_xfer |=> $stable(xinfo));  // R10
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == RA_NONE) |=> (rd_data == '0));  // R11
endmodule

// File: rtl/usb_irq_route.sv
module usb_irq_route
  import usb_irq_pkg::*;
#(
  parameter int NUM_GEN = 4,
  localparam int NEV    = NUM_FIXED + NUM_GEN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] pend,
  input  logic [NEV-1:0] mask,
  output logic           irq_lo,
  output logic           irq_hi,
  output logic           irq_wake
);
  localparam logic [NEV-1:0] HI_SEL = NEV'(1) << B_FAST;
  localparam logic [NEV-1:0] LO_SEL = ~HI_SEL;

  logic [NEV-1:0] live;
  assign live = pend & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo   <= 1'b0;
      irq_hi   <= 1'b0;
      irq_wake <= 1'b0;
    end else begin
      irq_lo   <= |(live & LO_SEL);
      irq_hi   <= |(live & HI_SEL);
      irq_wake <= live[B_WAKE];
    end
  end

  AST_HI_FROM_FAST: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(pend[B_FAST]));  // R6
  AST_WAKE_ALSO_LO: assert property (@(posedge clk) disable iff (rst)
    irq_wake |-> irq_lo);  // R8
  AST_LO_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq_lo);  // R5
endmodule

// File: rtl/usb_irq_router.sv
module usb_irq_router
  import usb_irq_pkg::*;
#(
  parameter int EP_W    = 4,
  parameter int NUM_GEN = 4,
  parameter int DW      = 16,
  localparam int NEV    = NUM_FIXED + NUM_GEN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_xfer,
  input  logic [EP_W-1:0]    ev_xfer_ep,
  input  logic               ev_xfer_in,
  input  logic               ev_xfer_fast,
  input  logic               ev_bus_reset,
  input  logic               ev_suspend,
  input  logic               ev_wakeup,
  input  logic [NUM_GEN-1:0] ev_gen,
  input  logic               susp_mode,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [1:0]         rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic               irq_lo,
  output logic               irq_hi,
  output logic               irq_wake
);
  logic [NEV-1:0] pend, mask, clr_vec;

  usb_irq_pending #(.EP_W(EP_W), .NUM_GEN(NUM_GEN)) u_pend (
    .clk(clk), .rst(rst),
    .ev_xfer(ev_xfer), .ev_xfer_ep(ev_xfer_ep), .ev_xfer_fast(ev_xfer_fast),
    .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend),
    .ev_wakeup(ev_wakeup), .ev_gen(ev_gen), .susp_mode(susp_mode),
    .clr_vec(clr_vec), .pend(pend)
  );

  usb_irq_regs #(.EP_W(EP_W), .NUM_GEN(NUM_GEN), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .ev_xfer(ev_xfer), .ev_xfer_ep(ev_xfer_ep), .ev_xfer_in(ev_xfer_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pend(pend),
    .mask(mask), .clr_vec(clr_vec), .rd_data(rd_data)
  );

  usb_irq_route #(.NUM_GEN(NUM_GEN)) u_route (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_wake(irq_wake)
  );
endmodule

// File: tb/usb_irq_router_tb.sv
module usb_irq_router_tb;
  localparam int EP_W = 4;
  localparam int NUM_GEN = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_xfer = 0, ev_xfer_in = 0, ev_xfer_fast = 0;
  logic [EP_W-1:0] ev_xfer_ep = '0;
  logic ev_bus_reset = 0, ev_suspend = 0, ev_wakeup = 0, susp_mode = 0;
  logic [NUM_GEN-1:0] ev_gen = '0;
  logic wr_en = 0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic irq_lo, irq_hi, irq_wake;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_irq_router #(.EP_W(EP_W), .NUM_GEN(NUM_GEN), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .ev_xfer(ev_xfer), .ev_xfer_ep(ev_xfer_ep),
    .ev_xfer_in(ev_xfer_in), .ev_xfer_fast(ev_xfer_fast),
    .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend),
    .ev_wakeup(ev_wakeup), .ev_gen(ev_gen), .susp_mode(susp_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_wake(irq_wake)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(logic [EP_W-1:0] ep, logic dir, logic fast);
    @(negedge clk);
    ev_xfer = 1; ev_xfer_ep = ep; ev_xfer_in = dir; ev_xfer_fast = fast;
    @(negedge clk);
    ev_xfer = 0; ev_xfer_fast = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 irq_lo", DW'(irq_lo), 0);
    check("R1 irq_hi", DW'(irq_hi), 0);
    check("R1 irq_wake", DW'(irq_wake), 0);
    check("R1 rd_data", rd_data, 0);
    rd(2'd0, v); check("R1 pend", v, 0);
    rd(2'd1, v); check("R1 mask", v, 0);
    rd(2'd2, v); check("R1 xinfo", v, 0);
  endtask

  task automatic t_sticky_mask();
    logic [DW-1:0] v;
    @(negedge clk); ev_bus_reset = 1; @(negedge clk); ev_bus_reset = 0;
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R2 bus reset sticky", v, 16'h0004);
    check("R9 masked event no line", DW'(irq_lo), 0);
    wr(2'd1, 16'h0004);
    rd(2'd1, v); check("R9 mask readback", v, 16'h0004);
    settle();
    check("R5 irq_lo on enabled", DW'(irq_lo), 1);
    check("R6 irq_hi quiet", DW'(irq_hi), 0);
  endtask

  task automatic t_clear();
    logic [DW-1:0] v;
    @(negedge clk); ev_suspend = 1; @(negedge clk); ev_suspend = 0;
    wr(2'd0, 16'hFFFB);
    rd(2'd0, v); check("R3 clear only bit2", v, 16'h0008);
    settle();
    check("R5 irq_lo drops when masked bit gone", DW'(irq_lo), 0);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R3 clear all", v, 0);
  endtask

  task automatic t_collision();
    logic [DW-1:0] v;
    @(negedge clk);
    ev_bus_reset = 1; wr_en = 1; wr_addr = 2'd0; wr_data = 16'h0000;
    @(negedge clk);
    ev_bus_reset = 0; wr_en = 0;
    rd(2'd0, v); check("R4 event beats clear", v, 16'h0004);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_fast();
    logic [DW-1:0] v;
    wr(2'd1, 16'h01FF);
    xfer(4'd5, 1'b1, 1'b1);
    rd(2'd0, v); check("R6 fast bits", v, 16'h0003);
    check("R6 irq_hi", DW'(irq_hi), 1);
    check("R5 irq_lo on transfer", DW'(irq_lo), 1);
    rd(2'd2, v); check("R10 xinfo ep5 in", v, 16'h0015);
    wr(2'd0, 16'hFFFD);
    settle();
    check("R6 irq_hi cleared", DW'(irq_hi), 0);
    check("R5 irq_lo still from bit0", DW'(irq_lo), 1);
    wr(2'd0, 16'h0000);
    settle();
    check("R5 irq_lo idle", DW'(irq_lo), 0);
  endtask

  task automatic t_ep0_and_slow();
    logic [DW-1:0] v;
    xfer(4'd0, 1'b0, 1'b1);
    rd(2'd0, v); check("R7 ep0 no fast bit", v, 16'h0001);
    check("R7 ep0 irq_hi", DW'(irq_hi), 0);
    rd(2'd2, v); check("R10 xinfo ep0 out", v, 16'h0000);
    wr(2'd0, 16'h0000);
    xfer(4'd3, 1'b0, 1'b0);
    rd(2'd0, v); check("R6 slow transfer no fast", v, 16'h0001);
    rd(2'd2, v); check("R10 xinfo ep3", v, 16'h0003);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); check("R10 write ignored", v, 16'h0003);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_wake();
    logic [DW-1:0] v;
    susp_mode = 0;
    @(negedge clk); ev_wakeup = 1; @(negedge clk); ev_wakeup = 0;
    settle();
    rd(2'd0, v); check("R8 wake outside suspend ignored", v, 0);
    check("R8 irq_wake quiet", DW'(irq_wake), 0);
    @(negedge clk); susp_mode = 1;
    @(negedge clk); ev_wakeup = 1; @(negedge clk); ev_wakeup = 0;
    settle();
    check("R8 irq_wake", DW'(irq_wake), 1);
    check("R5 wake on irq_lo", DW'(irq_lo), 1);
    rd(2'd0, v); check("R8 wake bit", v, 16'h0010);
    susp_mode = 0;
    wr(2'd0, 16'h0000);
    settle();
    check("R8 irq_wake cleared", DW'(irq_wake), 0);
  endtask

  task automatic t_gen_rdlat();
    logic [DW-1:0] v;
    wr(2'd1, 16'h0080);
    @(negedge clk); ev_gen = 4'b0100; @(negedge clk); ev_gen = '0;
    settle();
    check("R5 generic masked-in line", DW'(irq_lo), 1);
    rd(2'd0, v); check("R2 generic bit7", v, 16'h0080);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R3 write ones keeps", v, 16'h0080);
    @(negedge clk); rd_addr = 2'd2;
    #1 check("R11 old value before edge", rd_data, 16'h0080);
    @(negedge clk); check("R11 new value after edge", rd_data, 16'h0003);
    rd(2'd3, v); check("R11 addr3 zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sticky_mask();
    t_clear();
    t_collision();
    t_fast();
    t_ep0_and_slow();
    t_wake();
    t_gen_rdlat();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule